// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block turns one 32-bit floating-point instruction word into a set of decoded control fields. Its outputs are an operation code, an operand-form class, the register index fields, a sign-extended displacement, the small control-field extracts, a record flag, an update-writeback flag and an illegal flag. It recognises the memory-access encodings with a displacement or an index register, the arithmetic encodings for single and double precision, and the double-space moves, compares and status-register operations. It does not execute the operation, hold any register file or touch memory.

The decoder also forms the effective address for memory encodings. It does this through a combinational general-register read port: the block drives the two register indices taken from the word and gets the two register values back in the same cycle. The address adder can be left out with a parameter, and the address output then reads zero. All results are registered. A word presented with `in_valid` appears on the outputs one clock later, qualified by `out_valid`.

The update flag only requests that the base register be written back. The executing unit must drop that write if the operation traps.

Top module: `fp_insn_decoder`

## Requirements
- R1: For primary opcode values 48 to 55 (bits [31:26]), the op is OP_LD_S, OP_LD_D, OP_ST_S or OP_ST_D. Bit 28 selects store, bit 27 selects double and bit 26 selects update. The form is FM_DISP_UPD when bit 26 is set and FM_DISP otherwise.
- R2: For primary 31, the 10-bit extended field at bits [10:1] decodes as follows. 535 is OP_LD_S, 599 is OP_LD_D, 663 is OP_ST_S and 727 is OP_ST_D, all with form FM_IDX. 567, 631, 695 and 759 are the same four ops with form FM_IDX_UPD. 983 is OP_ST_IW with form FM_IDX.
- R3: For primary 59, the 5-bit field at bits [5:1] decodes with out_single=1. The ops are 18 OP_DIV, 20 OP_SUB, 21 OP_ADD, 22 OP_SQRT and 24 OP_RECIP_EST, all with form FM_RRR, and 25 OP_MUL with form FM_RRC. Values 28, 29, 30 and 31 give OP_FMS, OP_FMA, OP_NFMS and OP_NFMA with form FM_RRRR.
- R4: For primary 63 with bit 5 set, the same 5-bit field decodes as in R3 with out_single=0, with three changes. 23 is OP_SELECT (FM_RRRR), 26 is OP_RSQRT_EST (FM_RRR), and 24 is illegal.
- R5: For primary 63 with bit 5 clear, the 10-bit field at [10:1] decodes as follows.
  - 0 is OP_CMP_UNORD and 32 is OP_CMP_ORD, both FM_CMP.
  - 12 OP_ROUND_S, 14 OP_CVT_INT, 15 OP_CVT_INT_TZ, 40 OP_NEG, 72 OP_MOVE, 136 OP_NEG_ABS and 264 OP_ABS are all FM_TB.
  - 38 is OP_SET_BIT and 70 is OP_CLR_BIT, both FM_BIT.
  - 64 is OP_COPY_FIELD (FM_FLDCPY), 134 is OP_WRITE_IMM (FM_IMM), 583 is OP_READ_STATUS (FM_T) and 711 is OP_WRITE_FIELDS (FM_MASK).
- R6: On a legal word, out_rt is bits [25:21], out_ra is [20:16] and out_rc is [10:6]. out_rsrc2 is [15:11], except for form FM_RRC, where it is [10:6].
- R7: On a legal word, out_disp is bits [15:0] sign-extended to XLEN, out_crf is [25:23], out_imm is [15:12] and out_mask is [24:17].
- R8: The read port drives gpr_a_idx = bits [20:16] and gpr_b_idx = bits [15:11]. Let the base value be zero when out_ra is 0, and gpr_a_data otherwise. out_ea is the base value plus the displacement for displacement forms, and the base value plus gpr_b_data for indexed forms.
- R9: A displacement-update word with base index 0 is illegal. An indexed non-update word with base index 0 is illegal, except OP_ST_IW, which then addresses by gpr_b_data alone. An indexed-update word with base index 0 is legal.
- R10: out_update is 1 exactly for legal words of form FM_DISP_UPD or FM_IDX_UPD.
- R11: On a legal word, out_record equals bit 0 of the word.
- R12: Any other primary or extended value sets out_illegal. It also drives op OP_NONE, form FM_NONE and every other payload output to zero.
- R13: out_valid follows in_valid one clock later. While out_valid is 0, every payload output is zero. A synchronous active-high reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_insn | input | 32 | Instruction word |
| gpr_a_idx | output | 5 | Read-port index for the base register |
| gpr_b_idx | output | 5 | Read-port index for the index register |
| gpr_a_data | input | XLEN | Base register value |
| gpr_b_data | input | XLEN | Index register value |
| out_valid | output | 1 | Decoded result present |
| out_illegal | output | 1 | Word not recognised or base-zero violation |
| out_op | output | 6 | Operation code |
| out_form | output | 4 | Operand-form class |
| out_single | output | 1 | Single-precision arithmetic |
| out_rt | output | 5 | Target register index |
| out_ra | output | 5 | First source / base index |
| out_rsrc2 | output | 5 | Second source index |
| out_rc | output | 5 | Third source index |
| out_disp | output | XLEN | Sign-extended displacement |
| out_crf | output | 3 | Condition / status field number |
| out_imm | output | 4 | Status immediate |
| out_mask | output | 8 | Status field mask |
| out_record | output | 1 | Condition-register update requested |
| out_update | output | 1 | Base writeback requested |
| out_ea | output | XLEN | Effective address |

## Verification
Every result, including the effective address built from the read-port data, is due exactly one rising edge after the word is presented. The read port answers combinationally in the presentation cycle. The bench changes inputs on the falling edge and compares all outputs at the next falling edge, after the single register stage has loaded. This lets back-to-back words each be checked in their own cycle. Idle cycles and the reset period are checked the same way, against an all-zero expected result.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int PRI_W     = 6;
    localparam int XO_W      = 10;
    localparam int DISP_W    = 16;

    localparam logic [PRI_W-1:0] PRI_INDEXED = 6'd31;
    localparam logic [PRI_W-1:0] PRI_SINGLE  = 6'd59;
    localparam logic [PRI_W-1:0] PRI_DOUBLE  = 6'd63;

    typedef enum logic [5:0] {
        OP_NONE,
        OP_LD_S, OP_LD_D, OP_ST_S, OP_ST_D, OP_ST_IW,
        OP_DIV, OP_SUB, OP_ADD, OP_SQRT, OP_RECIP_EST, OP_MUL,
        OP_FMS, OP_FMA, OP_NFMS, OP_NFMA, OP_SELECT, OP_RSQRT_EST,
        OP_CMP_UNORD, OP_CMP_ORD, OP_ROUND_S, OP_CVT_INT, OP_CVT_INT_TZ,
        OP_SET_BIT, OP_CLR_BIT, OP_NEG, OP_MOVE, OP_NEG_ABS, OP_ABS,
        OP_COPY_FIELD, OP_READ_STATUS, OP_WRITE_FIELDS, OP_WRITE_IMM
    } fp_op_e;

    typedef enum logic [3:0] {
        FM_NONE,
        FM_RRR,      // target, A, B
        FM_RRC,      // target, A, C
        FM_RRRR,     // target, A, B, C
        FM_DISP,     // base + displacement
        FM_DISP_UPD, // base + displacement, base written back
        FM_IDX,      // base + index
        FM_IDX_UPD,  // base + index, base written back
        FM_T,        // target only
        FM_TB,       // target, B
        FM_CMP,      // condition field, A, B
        FM_FLDCPY,   // field to field copy
        FM_BIT,      // single status bit
        FM_IMM,      // status field immediate
        FM_MASK      // status fields under mask
    } fp_form_e;

endpackage

// File: rtl/fpdec_opsel.sv
module fpdec_opsel
    import fpdec_pkg::*;
(
    input  logic [PRI_W-1:0] primary,
    input  logic [XO_W-1:0]  xo,
    output fp_op_e           op,
    output fp_form_e         form,
    output logic             single,
    output logic             known
);

    logic a_space;
    logic dbl_space;

    always_comb begin
        op        = OP_NONE;
        form      = FM_NONE;
        single    = 1'b0;
        known     = 1'b1;
        dbl_space = (primary == PRI_DOUBLE);
        a_space   = (primary == PRI_SINGLE) || (dbl_space && xo[4]);

        if (primary[5:3] == 3'b110) begin
            // displacement memory group: bit2 store, bit1 double, bit0 update
            unique case (primary[2:1])
                2'b00:   op = OP_LD_S;
                2'b01:   op = OP_LD_D;
                2'b10:   op = OP_ST_S;
                default: op = OP_ST_D;
            endcase
            form = primary[0] ? FM_DISP_UPD : FM_DISP;
        end else if (primary == PRI_INDEXED) begin
            unique case (xo)
                10'd535: begin op = OP_LD_S;  form = FM_IDX;     end
                10'd567: begin op = OP_LD_S;  form = FM_IDX_UPD; end
                10'd599: begin op = OP_LD_D;  form = FM_IDX;     end
                10'd631: begin op = OP_LD_D;  form = FM_IDX_UPD; end
                10'd663: begin op = OP_ST_S;  form = FM_IDX;     end
                10'd695: begin op = OP_ST_S;  form = FM_IDX_UPD; end
                10'd727: begin op = OP_ST_D;  form = FM_IDX;     end
                10'd759: begin op = OP_ST_D;  form = FM_IDX_UPD; end
                10'd983: begin op = OP_ST_IW; form = FM_IDX;     end
                default: known = 1'b0;
            endcase
        end else if (a_space) begin
            single = !dbl_space;
            unique case (xo[4:0])
                5'd18: begin op = OP_DIV;  form = FM_RRR; end
                5'd20: begin op = OP_SUB;  form = FM_RRR; end
                5'd21: begin op = OP_ADD;  form = FM_RRR; end
                5'd22: begin op = OP_SQRT; form = FM_RRR; end
                5'd23: begin
                    if (dbl_space) begin op = OP_SELECT; form = FM_RRRR; end
                    else known = 1'b0;
                end
                5'd24: begin
                    if (!dbl_space) begin op = OP_RECIP_EST; form = FM_RRR; end
                    else known = 1'b0;
                end
                5'd25: begin op = OP_MUL;  form = FM_RRC; end
                5'd26: begin
                    if (dbl_space) begin op = OP_RSQRT_EST; form = FM_RRR; end
                    else known = 1'b0;
                end
                5'd28: begin op = OP_FMS;  form = FM_RRRR; end
                5'd29: begin op = OP_FMA;  form = FM_RRRR; end
                5'd30: begin op = OP_NFMS; form = FM_RRRR; end
                5'd31: begin op = OP_NFMA; form = FM_RRRR; end
                default: known = 1'b0;
            endcase
        end else if (dbl_space) begin
            unique case (xo)
                10'd0:   begin op = OP_CMP_UNORD;    form = FM_CMP;    end
                10'd12:  begin op = OP_ROUND_S;      form = FM_TB;     end
                10'd14:  begin op = OP_CVT_INT;      form = FM_TB;     end
                10'd15:  begin op = OP_CVT_INT_TZ;   form = FM_TB;     end
                10'd32:  begin op = OP_CMP_ORD;      form = FM_CMP;    end
                10'd38:  begin op = OP_SET_BIT;      form = FM_BIT;    end
                10'd40:  begin op = OP_NEG;          form = FM_TB;     end
                10'd64:  begin op = OP_COPY_FIELD;   form = FM_FLDCPY; end
                10'd70:  begin op = OP_CLR_BIT;      form = FM_BIT;    end
                10'd72:  begin op = OP_MOVE;         form = FM_TB;     end
                10'd134: begin op = OP_WRITE_IMM;    form = FM_IMM;    end
                10'd136: begin op = OP_NEG_ABS;      form = FM_TB;     end
                10'd264: begin op = OP_ABS;          form = FM_TB;     end
                10'd583: begin op = OP_READ_STATUS;  form = FM_T;      end
                10'd711: begin op = OP_WRITE_FIELDS; form = FM_MASK;   end
                default: known = 1'b0;
            endcase
        end else begin
            known = 1'b0;
        end

        if (!known) begin
            op     = OP_NONE;
            form   = FM_NONE;
            single = 1'b0;
        end
    end

endmodule

// File: rtl/fpdec_operands.sv
module fpdec_operands
    import fpdec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter bit EA_EN = 1'b1
) (
    input  logic [25:0]          fields,
    input  fp_form_e             form,
    input  fp_op_e               op,
    input  logic [XLEN-1:0]      base_val,
    input  logic [XLEN-1:0]      idx_val,
    output logic                 base_bad,
    output logic [REG_IDX_W-1:0] rt,
    output logic [REG_IDX_W-1:0] ra,
    output logic [REG_IDX_W-1:0] rsrc2,
    output logic [REG_IDX_W-1:0] rc,
    output logic [XLEN-1:0]      disp,
    output logic [2:0]           crf,
    output logic [3:0]           imm,
    output logic [7:0]           mask,
    output logic [XLEN-1:0]      ea
);

    localparam int EXT_W = XLEN - DISP_W;

    logic ra_zero;

    assign rt      = fields[25:21];
    assign ra      = fields[20:16];
    assign rc      = fields[10:6];
    assign rsrc2   = (form == FM_RRC) ? fields[10:6] : fields[15:11];
    assign disp    = {{EXT_W{fields[DISP_W-1]}}, fields[DISP_W-1:0]};
    assign crf     = fields[25:23];
    assign imm     = fields[15:12];
    assign mask    = fields[24:17];
    assign ra_zero = (ra == '0);

    // base index zero: displacement-update never allowed, indexed
    // non-update allowed only for the integer-word store
    assign base_bad = ra_zero &&
                      ((form == FM_DISP_UPD) ||
                       ((form == FM_IDX) && (op != OP_ST_IW)));

    generate
        if (EA_EN) begin : g_ea
            logic [XLEN-1:0] base_eff;
            always_comb begin
                base_eff = ra_zero ? '0 : base_val;
                unique case (form)
                    FM_DISP, FM_DISP_UPD: ea = base_eff + disp;
                    FM_IDX,  FM_IDX_UPD:  ea = base_eff + idx_val;
                    default:              ea = '0;
                endcase
            end
        end else begin : g_no_ea
            assign ea = '0;
        end
    endgenerate

endmodule

// File: rtl/fp_insn_decoder.sv
module fp_insn_decoder
    import fpdec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter bit EA_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    in_insn,
    output logic [REG_IDX_W-1:0] gpr_a_idx,
    output logic [REG_IDX_W-1:0] gpr_b_idx,
    input  logic [XLEN-1:0]      gpr_a_data,
    input  logic [XLEN-1:0]      gpr_b_data,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [5:0]           out_op,
    output logic [3:0]           out_form,
    output logic                 out_single,
    output logic [REG_IDX_W-1:0] out_rt,
    output logic [REG_IDX_W-1:0] out_ra,
    output logic [REG_IDX_W-1:0] out_rsrc2,
    output logic [REG_IDX_W-1:0] out_rc,
    output logic [XLEN-1:0]      out_disp,
    output logic [2:0]           out_crf,
    output logic [3:0]           out_imm,
    output logic [7:0]           out_mask,
    output logic                 out_record,
    output logic                 out_update,
    output logic [XLEN-1:0]      out_ea
);

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        fp_op_e               op;
        fp_form_e             form;
        logic                 single;
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] ra;
        logic [REG_IDX_W-1:0] rsrc2;
        logic [REG_IDX_W-1:0] rc;
        logic [XLEN-1:0]      disp;
        logic [2:0]           crf;
        logic [3:0]           imm;
        logic [7:0]           mask;
        logic                 record;
        logic                 update;
        logic [XLEN-1:0]      ea;
    } dec_t;

    dec_t dec_d, dec_q;

    fp_op_e               sel_op;
    fp_form_e             sel_form;
    logic                 sel_single;
    logic                 sel_known;
    logic                 base_bad;
    logic [REG_IDX_W-1:0] f_rt, f_ra, f_rs2, f_rc;
    logic [XLEN-1:0]      f_disp, f_ea;
    logic [2:0]           f_crf;
    logic [3:0]           f_imm;
    logic [7:0]           f_mask;

    assign gpr_a_idx = in_insn[20:16];
    assign gpr_b_idx = in_insn[15:11];

    fpdec_opsel u_opsel (
        .primary (in_insn[31:26]),
        .xo      (in_insn[10:1]),
        .op      (sel_op),
        .form    (sel_form),
        .single  (sel_single),
        .known   (sel_known)
    );

    fpdec_operands #(
        .XLEN  (XLEN),
        .EA_EN (EA_EN)
    ) u_operands (
        .fields   (in_insn[25:0]),
        .form     (sel_form),
        .op       (sel_op),
        .base_val (gpr_a_data),
        .idx_val  (gpr_b_data),
        .base_bad (base_bad),
        .rt       (f_rt),
        .ra       (f_ra),
        .rsrc2    (f_rs2),
        .rc       (f_rc),
        .disp     (f_disp),
        .crf      (f_crf),
        .imm      (f_imm),
        .mask     (f_mask),
        .ea       (f_ea)
    );

    always_comb begin
        dec_d = '0;
        if (in_valid) begin
            dec_d.valid = 1'b1;
            if (!sel_known || base_bad) begin
                dec_d.illegal = 1'b1;
            end else begin
                dec_d.op     = sel_op;
                dec_d.form   = sel_form;
                dec_d.single = sel_single;
                dec_d.rt     = f_rt;
                dec_d.ra     = f_ra;
                dec_d.rsrc2  = f_rs2;
                dec_d.rc     = f_rc;
                dec_d.disp   = f_disp;
                dec_d.crf    = f_crf;
                dec_d.imm    = f_imm;
                dec_d.mask   = f_mask;
                dec_d.record = in_insn[0];
                dec_d.update = (sel_form == FM_DISP_UPD) || (sel_form == FM_IDX_UPD);
                dec_d.ea     = f_ea;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign out_valid   = dec_q.valid;
    assign out_illegal = dec_q.illegal;
    assign out_op      = dec_q.op;
    assign out_form    = dec_q.form;
    assign out_single  = dec_q.single;
    assign out_rt      = dec_q.rt;
    assign out_ra      = dec_q.ra;
    assign out_rsrc2   = dec_q.rsrc2;
    assign out_rc      = dec_q.rc;
    assign out_disp    = dec_q.disp;
    assign out_crf     = dec_q.crf;
    assign out_imm     = dec_q.imm;
    assign out_mask    = dec_q.mask;
    assign out_record  = dec_q.record;
    assign out_update  = dec_q.update;
    assign out_ea      = dec_q.ea;

    a_r13_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r13_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_ea == '0));

    a_r12_illegal_clean: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (dec_q.op == OP_NONE && dec_q.form == FM_NONE &&
                         !out_update && !out_record && out_valid));

    a_r9_upd_base_nonzero: assert property (@(posedge clk) disable iff (rst)
        (out_update && dec_q.form == FM_DISP_UPD) |-> (out_ra != '0));

    a_r6_mul_takes_c: assert property (@(posedge clk) disable iff (rst)
        (dec_q.form == FM_RRC) |-> (dec_q.op == OP_MUL && out_rsrc2 == out_rc));

    a_r3_single_arith: assert property (@(posedge clk) disable iff (rst)
        out_single |-> (dec_q.form inside {FM_RRR, FM_RRC, FM_RRRR}));

    a_r10_update_form: assert property (@(posedge clk) disable iff (rst)
        out_update |-> (dec_q.form inside {FM_DISP_UPD, FM_IDX_UPD}));

endmodule

// File: tb/sim_fp_insn_decoder.sv
module sim_fp_insn_decoder;
    import fpdec_pkg::*;

    localparam int XLEN = 32;

    typedef struct packed {
        logic        valid;
        logic        illegal;
        logic [5:0]  op;
        logic [3:0]  form;
        logic        single;
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [4:0]  rs2;
        logic [4:0]  rc;
        logic [31:0] disp;
        logic [2:0]  crf;
        logic [3:0]  imm;
        logic [7:0]  mask;
        logic        record;
        logic        update;
        logic [31:0] ea;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [4:0]  gpr_a_idx, gpr_b_idx;
    logic [31:0] gpr_a_data, gpr_b_data;
    logic        out_valid, out_illegal, out_single, out_record, out_update;
    logic [5:0]  out_op;
    logic [3:0]  out_form;
    logic [4:0]  out_rt, out_ra, out_rsrc2, out_rc;
    logic [31:0] out_disp, out_ea;
    logic [2:0]  out_crf;
    logic [3:0]  out_imm;
    logic [7:0]  out_mask;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [31:0] regval(input logic [4:0] i);
        return 32'h9E37_79B9 * ({27'd0, i} + 32'd1);
    endfunction

    assign gpr_a_data = regval(gpr_a_idx);
    assign gpr_b_data = regval(gpr_b_idx);

    fp_insn_decoder #(.XLEN(XLEN), .EA_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .gpr_a_idx(gpr_a_idx), .gpr_b_idx(gpr_b_idx),
        .gpr_a_data(gpr_a_data), .gpr_b_data(gpr_b_data),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_op(out_op),
        .out_form(out_form), .out_single(out_single), .out_rt(out_rt),
        .out_ra(out_ra), .out_rsrc2(out_rsrc2), .out_rc(out_rc),
        .out_disp(out_disp), .out_crf(out_crf), .out_imm(out_imm),
        .out_mask(out_mask), .out_record(out_record), .out_update(out_update),
        .out_ea(out_ea)
    );

    // Expected result from the requirements
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [5:0] p;
        logic [9:0] x;
        logic ok;
        logic [31:0] base;
        p  = w[31:26];
        x  = w[10:1];
        ok = 1'b1;
        e  = '0;
        e.valid = 1'b1;
        if (p >= 6'd48 && p <= 6'd55) begin                      // R1
            case (p)
                6'd48, 6'd49: e.op = OP_LD_S;
                6'd50, 6'd51: e.op = OP_LD_D;
                6'd52, 6'd53: e.op = OP_ST_S;
                default:      e.op = OP_ST_D;
            endcase
            e.form = p[0] ? FM_DISP_UPD : FM_DISP;
        end else if (p == 6'd31) begin                           // R2
            case (x)
                10'd535: begin e.op = OP_LD_S;  e.form = FM_IDX;     end
                10'd567: begin e.op = OP_LD_S;  e.form = FM_IDX_UPD; end
                10'd599: begin e.op = OP_LD_D;  e.form = FM_IDX;     end
                10'd631: begin e.op = OP_LD_D;  e.form = FM_IDX_UPD; end
                10'd663: begin e.op = OP_ST_S;  e.form = FM_IDX;     end
                10'd695: begin e.op = OP_ST_S;  e.form = FM_IDX_UPD; end
                10'd727: begin e.op = OP_ST_D;  e.form = FM_IDX;     end
                10'd759: begin e.op = OP_ST_D;  e.form = FM_IDX_UPD; end
                10'd983: begin e.op = OP_ST_IW; e.form = FM_IDX;     end
                default: ok = 1'b0;
            endcase
        end else if (p == 6'd59 || (p == 6'd63 && w[5])) begin   // R3 R4
            e.single = (p == 6'd59);
            case (x[4:0])
                5'd18: begin e.op = OP_DIV;  e.form = FM_RRR; end
                5'd20: begin e.op = OP_SUB;  e.form = FM_RRR; end
                5'd21: begin e.op = OP_ADD;  e.form = FM_RRR; end
                5'd22: begin e.op = OP_SQRT; e.form = FM_RRR; end
                5'd23: if (p == 6'd63) begin e.op = OP_SELECT; e.form = FM_RRRR; end else ok = 1'b0;
                5'd24: if (p == 6'd59) begin e.op = OP_RECIP_EST; e.form = FM_RRR; end else ok = 1'b0;
                5'd25: begin e.op = OP_MUL;  e.form = FM_RRC; end
                5'd26: if (p == 6'd63) begin e.op = OP_RSQRT_EST; e.form = FM_RRR; end else ok = 1'b0;
                5'd28: begin e.op = OP_FMS;  e.form = FM_RRRR; end
                5'd29: begin e.op = OP_FMA;  e.form = FM_RRRR; end
                5'd30: begin e.op = OP_NFMS; e.form = FM_RRRR; end
                5'd31: begin e.op = OP_NFMA; e.form = FM_RRRR; end
                default: ok = 1'b0;
            endcase
        end else if (p == 6'd63) begin                           // R5
            case (x)
                10'd0:   begin e.op = OP_CMP_UNORD;    e.form = FM_CMP;    end
                10'd12:  begin e.op = OP_ROUND_S;      e.form = FM_TB;     end
                10'd14:  begin e.op = OP_CVT_INT;      e.form = FM_TB;     end
                10'd15:  begin e.op = OP_CVT_INT_TZ;   e.form = FM_TB;     end
                10'd32:  begin e.op = OP_CMP_ORD;      e.form = FM_CMP;    end
                10'd38:  begin e.op = OP_SET_BIT;      e.form = FM_BIT;    end
                10'd40:  begin e.op = OP_NEG;          e.form = FM_TB;     end
                10'd64:  begin e.op = OP_COPY_FIELD;   e.form = FM_FLDCPY; end
                10'd70:  begin e.op = OP_CLR_BIT;      e.form = FM_BIT;    end
                10'd72:  begin e.op = OP_MOVE;         e.form = FM_TB;     end
                10'd134: begin e.op = OP_WRITE_IMM;    e.form = FM_IMM;    end
                10'd136: begin e.op = OP_NEG_ABS;      e.form = FM_TB;     end
                10'd264: begin e.op = OP_ABS;          e.form = FM_TB;     end
                10'd583: begin e.op = OP_READ_STATUS;  e.form = FM_T;      end
                10'd711: begin e.op = OP_WRITE_FIELDS; e.form = FM_MASK;   end
                default: ok = 1'b0;
            endcase
        end else begin
            ok = 1'b0;
        end
        // R9 base-zero rules
        if (ok && w[20:16] == 5'd0) begin
            if (e.form == FM_DISP_UPD) ok = 1'b0;
            if (e.form == FM_IDX && e.op != OP_ST_IW) ok = 1'b0;
        end
        if (!ok) begin                                           // R12
            e = '0;
            e.valid   = 1'b1;
            e.illegal = 1'b1;
            return e;
        end
        e.rt     = w[25:21];                                     // R6
        e.ra     = w[20:16];
        e.rc     = w[10:6];
        e.rs2    = (e.form == FM_RRC) ? w[10:6] : w[15:11];
        e.disp   = {{16{w[15]}}, w[15:0]};                       // R7
        e.crf    = w[25:23];
        e.imm    = w[15:12];
        e.mask   = w[24:17];
        e.record = w[0];                                         // R11
        e.update = (e.form == FM_DISP_UPD || e.form == FM_IDX_UPD); // R10
        base     = (w[20:16] == 5'd0) ? 32'd0 : regval(w[20:16]); // R8
        if (e.form == FM_DISP || e.form == FM_DISP_UPD) e.ea = base + e.disp;
        else if (e.form == FM_IDX || e.form == FM_IDX_UPD) e.ea = base + regval(w[15:11]);
        return e;
    endfunction

    function automatic logic [31:0] mkd(input int p, input int rt, input int ra, input logic [15:0] d);
        return {6'(p), 5'(rt), 5'(ra), d};
    endfunction

    function automatic logic [31:0] mkx(input int p, input int rt, input int ra, input int rb,
                                        input int xo, input bit rec);
        return {6'(p), 5'(rt), 5'(ra), 5'(rb), 10'(xo), rec};
    endfunction

    function automatic logic [31:0] mka(input int p, input int rt, input int ra, input int rb,
                                        input int rc, input int xo, input bit rec);
        return {6'(p), 5'(rt), 5'(ra), 5'(rb), 5'(rc), 5'(xo), rec};
    endfunction

    function automatic logic [9:0] pick_idx(input int k);
        case (k)
            0: return 10'd535; 1: return 10'd567; 2: return 10'd599;
            3: return 10'd631; 4: return 10'd663; 5: return 10'd695;
            6: return 10'd727; 7: return 10'd759; default: return 10'd983;
        endcase
    endfunction

    function automatic logic [9:0] pick_x(input int k);
        case (k)
            0: return 10'd0;   1: return 10'd12;  2: return 10'd14;
            3: return 10'd15;  4: return 10'd32;  5: return 10'd38;
            6: return 10'd40;  7: return 10'd64;  8: return 10'd70;
            9: return 10'd72;  10: return 10'd134; 11: return 10'd136;
            12: return 10'd264; 13: return 10'd583; default: return 10'd711;
        endcase
    endfunction

    task automatic compare(input exp_t e, input string tag, input logic [31:0] w);
        exp_t a;
        a = {out_valid, out_illegal, out_op, out_form, out_single, out_rt, out_ra,
             out_rsrc2, out_rc, out_disp, out_crf, out_imm, out_mask, out_record,
             out_update, out_ea};
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s insn=%h actual=%h expected=%h", tag, w, a, e);
        end
    endtask

    task automatic issue(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        @(negedge clk);
        compare(model(w), tag, w);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_insn  = $urandom;
        @(negedge clk);
        compare('0, tag, in_insn);
    endtask

    initial begin
        logic [31:0] w;
        int sel;
        void'($urandom(32'd20240611));
        // R13 reset: inputs active while reset held
        in_valid = 1'b1;
        in_insn  = mkd(50, 1, 2, 16'h0040);
        repeat (3) @(negedge clk);
        compare('0, "R13 reset", in_insn);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        issue(mkd(50, 3, 4, 16'hFFF0), "R1 R7 R8 load double neg disp");
        issue(mkd(49, 5, 6, 16'h0123), "R1 R10 load single update");
        issue(mkd(55, 7, 8, 16'h8000), "R1 R10 store double update");
        issue(mkd(52, 9, 0, 16'h0010), "R8 disp base zero means 0");
        issue(mkd(49, 5, 0, 16'h0004), "R9 disp update base zero illegal");
        issue(mkx(31, 2, 4, 7, 599, 0), "R2 R8 indexed load double");
        issue(mkx(31, 2, 4, 7, 759, 0), "R2 R10 indexed store update");
        issue(mkx(31, 2, 0, 7, 535, 0), "R9 indexed base zero illegal");
        issue(mkx(31, 2, 0, 9, 983, 0), "R9 R2 int-word store base zero");
        issue(mkx(31, 2, 0, 9, 567, 0), "R9 indexed update base zero legal");
        issue(mkx(31, 2, 3, 9, 536, 0), "R12 unknown indexed ext");
        issue(mka(59, 1, 2, 3, 4, 25, 0), "R3 R6 single multiply uses C");
        issue(mka(59, 1, 2, 3, 4, 24, 1), "R3 R11 reciprocal estimate");
        issue(mka(59, 1, 2, 3, 4, 23, 0), "R12 select absent in single");
        issue(mka(63, 6, 7, 8, 9, 23, 0), "R4 double select");
        issue(mka(63, 6, 7, 8, 9, 26, 0), "R4 rsqrt estimate");
        issue(mka(63, 6, 7, 8, 9, 24, 0), "R4 R12 recip absent in double");
        issue(mkx(63, 20, 1, 2, 0, 1), "R5 R7 compare field");
        issue(mkx(63, 5'b10111, 5'b01100, 5'b10110, 134, 0), "R5 R7 status immediate");
        issue(mkx(63, 5'b01101, 5'b10011, 3, 711, 1), "R5 R7 R11 status mask");
        issue(mkx(63, 4, 0, 5, 72, 1), "R11 move with record");
        issue(mkx(63, 4, 0, 5, 73, 1), "R12 unknown X ext clears record");
        issue(mkd(12, 4, 5, 16'hFFFF), "R12 unknown primary");
        idle("R13 idle cycle");
        issue(mkx(63, 4, 0, 5, 583, 0), "R5 read status after idle");

        for (int i = 0; i < 400; i++) begin
            w   = $urandom;
            sel = int'($urandom % 8);
            case (sel)
                0: w[31:26] = 6'(48 + ($urandom % 8));
                1, 2: begin
                    w[31:26] = 6'd31;
                    if ($urandom % 4 != 0) w[10:1] = pick_idx(int'($urandom % 9));
                end
                3: w[31:26] = 6'd59;
                4, 5: begin
                    w[31:26] = 6'd63;
                    if (!w[5] && ($urandom % 4 != 0)) w[10:1] = pick_x(int'($urandom % 15));
                end
                default: ;
            endcase
            if ($urandom % 4 == 0) w[20:16] = 5'd0;
            if ($urandom % 16 == 0) idle("R13 random idle");
            else issue(w, "random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12");
        end
        idle("R13 final idle");

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule